// File: doc/BRIEF.md
# Microcoded ALU Stage with Flag Register

This block is the arithmetic stage of a 16-bit microcoded datapath. Each cycle it takes a left operand from the L bus. It also takes a right operand, chosen by a microinstruction field from three sources: a memory-data word, a fault-code word, or one of four small constants. It then produces a result word `z_out` in the same cycle. The microinstruction can name AND, SUB or ADD directly. It can also hand the choice to three bits of the instruction register, which adds OR, XOR, compare and pass operations.

A size bit narrows the operation to the low byte. In that mode the flags come from the byte and the upper half of the result is zero. A carry-select bit chains the stored carry into add and subtract. A shift control moves the result right by one position. The next flag nibble is always available on `flags_next`. It is loaded into the flag register `flags_q` only on cycles where the set-flags control is high.

Top module: `alu_flag_stage`

## Requirements
- R1: `r_src` picks the right operand: 0 = `mem_data`, 1 = the coded constant, 2 = `fault_code`, 3 = zero.
- R2: `imm_code` selects the constant: 0 gives 0x0000, 1 gives 0x0001, 2 gives 0xFFFE, 3 gives 0xFFFF.
- R3: `op_sel` 1 performs AND, 2 performs SUB (L minus R) and 3 performs ADD.
- R4: `op_sel` 0 takes the operation from `ir_op`: 000 ADD, 001 SUB, 010 ADD, 011 compare, 100 OR, 101 AND, 110 XOR, 111 pass L.
- R5: A compare drives `z_out` with the (size-masked) L operand unchanged, and computes all four flags from L minus R.
- R6: With `carry_sel` high, the stored C flag (`flags_q` bit 1) is added by ADD and subtracted as a borrow by SUB. With `carry_sel` low, the carry-in is 0.
- R7: For ADD, C is the carry out. For SUB and compare, C is the borrow, which is 1 when L < R + carry-in unsigned. V flags a signed overflow. OR, AND, XOR and pass clear C and V.
- R8: With `byte_mode` high, only bits 7:0 of the operands take part. C is the carry or borrow out of bit 7, N is bit 7, Z tests the low byte, and `z_out[15:8]` is 0.
- R9: With `shift_right` high, the result is shifted right logically by one bit within the active width. C is bit 0 of the unshifted result, V is 0, and Z and N come from the shifted value. A compare still outputs L.
- R10: Reset clears `flags_q`. `flags_q` loads `flags_next` on a clock edge where `set_flags` is high, and keeps its value otherwise.
- R11: The flag nibble is bit 3 = Z (result zero), bit 2 = N (sign bit of the active width), bit 1 = C, bit 0 = V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_bus | input | 16 | Left operand |
| mem_data | input | 16 | Memory-data right operand source |
| fault_code | input | 16 | Fault-code right operand source |
| r_src | input | 2 | Right operand source select |
| imm_code | input | 2 | Coded constant select |
| op_sel | input | 2 | Operation select |
| ir_op | input | 3 | Instruction-register operation bits |
| byte_mode | input | 1 | 1 = 8-bit operation |
| carry_sel | input | 1 | 1 = use stored carry as carry-in |
| shift_right | input | 1 | Shift result right by one |
| set_flags | input | 1 | Load flag register this cycle |
| z_out | output | 16 | Result |
| flags_next | output | 4 | Flags computed this cycle {Z,N,C,V} |
| flags_q | output | 4 | Stored flags {Z,N,C,V} |

## Verification
Two functions can fall in the same cycle: the flag register loading a new carry, and an add or subtract that reads the stored carry as its carry-in. The bench issues back-to-back operations with both `set_flags` and `carry_sel` high. In each of those cycles it checks that the carry-in is the carry stored at the previous edge, not the one being produced now. It judges the result against a bench-side model that keeps its own copy of the flag register.

// File: rtl/alu_flag_stage.sv
module alu_flag_stage #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] l_bus,
  input  logic [W-1:0] mem_data,
  input  logic [W-1:0] fault_code,
  input  logic [1:0]   r_src,
  input  logic [1:0]   imm_code,
  input  logic [1:0]   op_sel,
  input  logic [2:0]   ir_op,
  input  logic         byte_mode,
  input  logic         carry_sel,
  input  logic         shift_right,
  input  logic         set_flags,
  output logic [W-1:0] z_out,
  output logic [3:0]   flags_next,
  output logic [3:0]   flags_q
);

  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  typedef enum logic [2:0] {K_ADD, K_SUB, K_CMP, K_OR, K_AND, K_XOR, K_PASS} kind_t;

  kind_t        kind;
  logic [W-1:0] imm_val, r_opnd, mask, a, b, value, shifted, fsrc;
  logic [W:0]   sum, diff;
  logic         cin, cout, ovf, sa, sb, sr;

  always_comb begin
    case (imm_code)
      2'd0:    imm_val = '0;
      2'd1:    imm_val = {{(W-1){1'b0}}, 1'b1};
      2'd2:    imm_val = {{(W-1){1'b1}}, 1'b0};
      default: imm_val = '1;
    endcase
  end

  always_comb begin
    case (r_src)
      2'd0:    r_opnd = mem_data;
      2'd1:    r_opnd = imm_val;
      2'd2:    r_opnd = fault_code;
      default: r_opnd = '0;
    endcase
  end

  always_comb begin
    case (op_sel)
      2'd1: kind = K_AND;
      2'd2: kind = K_SUB;
      2'd3: kind = K_ADD;
      default:
        case (ir_op)
          3'd0, 3'd2: kind = K_ADD;
          3'd1:       kind = K_SUB;
          3'd3:       kind = K_CMP;
          3'd4:       kind = K_OR;
          3'd5:       kind = K_AND;
          3'd6:       kind = K_XOR;
          default:    kind = K_PASS;
        endcase
    endcase
  end

  assign mask = byte_mode ? {{(W-BW){1'b0}}, {BW{1'b1}}} : '1;
  assign a    = l_bus & mask;
  assign b    = r_opnd & mask;
  assign cin  = carry_sel & flags_q[FC];
  assign sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign diff = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};

  always_comb begin
    value = '0;
    cout  = 1'b0;
    case (kind)
      K_ADD: begin
        value = sum[W-1:0] & mask;
        cout  = byte_mode ? sum[BW] : sum[W];
      end
      K_SUB, K_CMP: begin
        value = diff[W-1:0] & mask;
        cout  = byte_mode ? diff[BW] : diff[W];
      end
      K_OR:    value = a | b;
      K_AND:   value = a & b;
      K_XOR:   value = a ^ b;
      default: value = a;
    endcase
  end

  assign sa  = byte_mode ? a[BW-1] : a[W-1];
  assign sb  = byte_mode ? b[BW-1] : b[W-1];
  assign sr  = byte_mode ? value[BW-1] : value[W-1];
  assign ovf = (kind == K_ADD) ? ((sa == sb) && (sr != sa)) :
               (kind == K_SUB || kind == K_CMP) ? ((sa != sb) && (sr != sa)) : 1'b0;

  assign shifted = value >> 1;
  assign z_out   = (kind == K_CMP) ? a : (shift_right ? shifted : value);
  assign fsrc    = shift_right ? shifted : value;

  assign flags_next[FZ] = (fsrc == '0);
  assign flags_next[FN] = byte_mode ? fsrc[BW-1] : fsrc[W-1];
  assign flags_next[FC] = shift_right ? value[0] : cout;
  assign flags_next[FV] = shift_right ? 1'b0 : ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (set_flags) flags_q <= flags_next;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags_q));
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q == $past(flags_next));
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> z_out[W-1:BW] == '0);
  a_r9_shift_top: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_right && !byte_mode && !(op_sel == 2'd0 && ir_op == 3'd3)) |-> (z_out[W-1] == 1'b0 && flags_next[FV] == 1'b0));
  a_r11_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_sel == 2'd0 && ir_op == 3'd3) |-> flags_next[FZ] == (z_out == '0));

endmodule

// File: tb/alu_flag_stage_tb.sv
module alu_flag_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] l_bus = '0, mem_data = '0, fault_code = '0;
  logic [1:0]  r_src = '0, imm_code = '0, op_sel = '0;
  logic [2:0]  ir_op = '0;
  logic        byte_mode = 1'b0, carry_sel = 1'b0, shift_right = 1'b0, set_flags = 1'b0;
  logic [15:0] z_out;
  logic [3:0]  flags_next, flags_q;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_q = 4'h0;

  always #2 clk = ~clk;

  alu_flag_stage u_dut (
    .clk(clk), .rst_n(rst_n), .l_bus(l_bus), .mem_data(mem_data), .fault_code(fault_code),
    .r_src(r_src), .imm_code(imm_code), .op_sel(op_sel), .ir_op(ir_op), .byte_mode(byte_mode),
    .carry_sel(carry_sel), .shift_right(shift_right), .set_flags(set_flags),
    .z_out(z_out), .flags_next(flags_next), .flags_q(flags_q));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench op codes: 0 ADD 1 SUB 2 CMP 3 OR 4 AND 5 XOR 6 PASS
  function automatic int op_of(logic [1:0] os, logic [2:0] ir);
    if (os == 2'd1) return 4;
    if (os == 2'd2) return 1;
    if (os == 2'd3) return 0;
    case (ir)
      3'd0, 3'd2: return 0;
      3'd1: return 1;
      3'd3: return 2;
      3'd4: return 3;
      3'd5: return 4;
      3'd6: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [19:0] ref_model(logic [15:0] l, logic [15:0] r, int op,
                                            logic bm, logic ci, logic shr);
    int w, m, la, rb, res, val, sh, fs, c, v, sa, sb, sr, zo;
    w = bm ? 8 : 16;
    m = (1 << w) - 1;
    la = l & m; rb = r & m;
    c = 0; v = 0;
    case (op)
      0: begin res = la + rb + ci; c = (res >> w) & 1; end
      1, 2: begin res = la - rb - ci; c = (la < rb + ci) ? 1 : 0; end
      3: res = la | rb;
      4: res = la & rb;
      5: res = la ^ rb;
      default: res = la;
    endcase
    val = res & m;
    sa = (la >> (w-1)) & 1; sb = (rb >> (w-1)) & 1; sr = (val >> (w-1)) & 1;
    if (op == 0) v = (sa == sb && sr != sa) ? 1 : 0;
    if (op == 1 || op == 2) v = (sa != sb && sr != sa) ? 1 : 0;
    sh = val >> 1;
    fs = shr ? sh : val;
    zo = (op == 2) ? la : fs;
    if (shr) begin c = val & 1; v = 0; end
    return {zo[15:0], (fs == 0), fs[w-1], c[0], v[0]};
  endfunction

  task automatic run(string req, logic [15:0] l, logic [1:0] rs, logic [15:0] rv, logic [1:0] imm,
                     logic [1:0] os, logic [2:0] ir, logic bm, logic uc, logic shr, logic sf);
    logic [15:0] rop;
    logic [19:0] e;
    @(negedge clk);
    check("R10 stored flags", flags_q, exp_q);
    l_bus = l; r_src = rs; mem_data = rv; fault_code = rv ^ 16'h5A5A; imm_code = imm;
    op_sel = os; ir_op = ir; byte_mode = bm; carry_sel = uc; shift_right = shr; set_flags = sf;
    #1;
    case (rs)
      2'd0: rop = rv;
      2'd1: rop = (imm == 0) ? 16'h0000 : (imm == 1) ? 16'h0001 : (imm == 2) ? 16'hFFFE : 16'hFFFF;
      2'd2: rop = rv ^ 16'h5A5A;
      default: rop = 16'h0000;
    endcase
    e = ref_model(l, rop, op_of(os, ir), bm, uc & exp_q[1], shr);
    check({req, " z_out"}, z_out, e[19:4]);
    check({req, " flags_next"}, flags_next, e[3:0]);
    if (sf) exp_q = e[3:0];
  endtask

  task automatic t_reset;
    check("R10 reset flags", flags_q, 4'h0);
  endtask

  task automatic t_sources;
    run("R1 mem", 16'h1000, 2'd0, 16'h0234, 2'd0, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R1 mem literal", z_out, 16'h1234);
    run("R1 fault", 16'h1000, 2'd2, 16'h0000, 2'd0, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R1 fault literal", z_out, 16'h6A5A);
    run("R1 zero", 16'h1000, 2'd3, 16'hFFFF, 2'd3, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R1 zero literal", z_out, 16'h1000);
    for (int i = 0; i < 4; i++) run("R2 imm", 16'h0010, 2'd1, 16'h0, 2'(i), 2'd3, 3'd0, 0, 0, 0, 0);
    check("R2 imm3 literal", z_out, 16'h000F);
    run("R2 imm2", 16'h0010, 2'd1, 16'h0, 2'd2, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R2 imm2 literal", z_out, 16'h000E);
  endtask

  task automatic t_ops;
    run("R3 and", 16'hF0F0, 2'd0, 16'h3C3C, 2'd0, 2'd1, 3'd6, 0, 0, 0, 0);
    check("R3 and literal", z_out, 16'h3030);
    run("R3 sub", 16'h0100, 2'd0, 16'h0001, 2'd0, 2'd2, 3'd6, 0, 0, 0, 0);
    check("R3 sub literal", z_out, 16'h00FF);
    run("R3 add", 16'h1111, 2'd0, 16'h2222, 2'd0, 2'd3, 3'd1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) run("R4 ir op", 16'hA5C3, 2'd0, 16'h0F35, 2'd0, 2'd0, 3'(i), 0, 0, 0, 0);
    run("R4 xor", 16'hFF00, 2'd0, 16'h0FF0, 2'd0, 2'd0, 3'd6, 0, 0, 0, 0);
    check("R4 xor literal", z_out, 16'hF0F0);
    run("R5 cmp", 16'h0003, 2'd0, 16'h0005, 2'd0, 2'd0, 3'd3, 0, 0, 0, 0);
    check("R5 cmp z is L", z_out, 16'h0003);
    check("R5 cmp flags", flags_next, 4'b0110);
    run("R5 cmp equal", 16'h4444, 2'd0, 16'h4444, 2'd0, 2'd0, 3'd3, 0, 0, 0, 0);
    check("R5 cmp eq flags", flags_next, 4'b1000);
  endtask

  task automatic t_flags;
    run("R7 borrow", 16'h0003, 2'd0, 16'h0005, 2'd0, 2'd2, 3'd0, 0, 0, 0, 0);
    check("R7 borrow flags", flags_next, 4'b0110);
    run("R7 ovf add", 16'h7FFF, 2'd1, 16'h0, 2'd1, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R11 ovf flags", flags_next, 4'b0101);
    run("R7 carry add", 16'hFFFF, 2'd1, 16'h0, 2'd1, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R11 zero carry flags", flags_next, 4'b1010);
    run("R7 sub ovf", 16'h8000, 2'd1, 16'h0, 2'd1, 2'd2, 3'd0, 0, 0, 0, 0);
    check("R7 sub ovf flags", flags_next, 4'b0001);
    run("R7 logic clears", 16'h8000, 2'd0, 16'h8000, 2'd0, 2'd0, 3'd4, 0, 0, 0, 0);
    check("R7 or flags", flags_next, 4'b0100);
  endtask

  task automatic t_carry;
    run("R6 make carry", 16'hFFFF, 2'd1, 16'h0, 2'd1, 2'd3, 3'd0, 0, 0, 0, 1);
    run("R6 adc chain", 16'h0005, 2'd0, 16'h0003, 2'd0, 2'd3, 3'd0, 0, 1, 0, 1);
    check("R6 adc literal", z_out, 16'h0009);
    run("R6 no carry sel", 16'h0005, 2'd0, 16'h0003, 2'd0, 2'd3, 3'd0, 0, 0, 0, 1);
    run("R6 set borrow", 16'h0000, 2'd1, 16'h0, 2'd1, 2'd2, 3'd0, 0, 0, 0, 1);
    run("R6 sbc chain", 16'h0010, 2'd0, 16'h0003, 2'd0, 2'd2, 3'd0, 0, 1, 0, 1);
    check("R6 sbc literal", z_out, 16'h000C);
    run("R6 sbc after clear", 16'h0010, 2'd0, 16'h0003, 2'd0, 2'd2, 3'd0, 0, 1, 0, 1);
    check("R6 sbc literal 2", z_out, 16'h000D);
  endtask

  task automatic t_byte;
    run("R8 byte add", 16'hAB80, 2'd0, 16'h3380, 2'd0, 2'd3, 3'd0, 1, 0, 0, 0);
    check("R8 byte z", z_out, 16'h0000);
    check("R8 byte flags", flags_next, 4'b1011);
    run("R8 byte sub", 16'hFF01, 2'd1, 16'h0, 2'd1, 2'd2, 3'd0, 1, 0, 0, 0);
    check("R8 byte sub z", z_out, 16'h0000);
    run("R8 byte borrow", 16'h1200, 2'd1, 16'h0, 2'd1, 2'd2, 3'd0, 1, 0, 0, 0);
    check("R8 byte borrow z", z_out, 16'h00FF);
    check("R8 byte borrow flags", flags_next, 4'b0110);
    run("R8 byte cmp", 16'hEE7F, 2'd0, 16'h00FF, 2'd0, 2'd0, 3'd3, 1, 0, 0, 0);
  endtask

  task automatic t_shift;
    run("R9 shift pass", 16'h0003, 2'd0, 16'h0, 2'd0, 2'd0, 3'd7, 0, 0, 1, 0);
    check("R9 shift z", z_out, 16'h0001);
    check("R9 shift flags", flags_next, 4'b0010);
    run("R9 shift byte", 16'h12FF, 2'd0, 16'h0, 2'd0, 2'd0, 3'd7, 1, 0, 1, 0);
    check("R9 shift byte z", z_out, 16'h007F);
    run("R9 shift add", 16'h8000, 2'd0, 16'h8000, 2'd0, 2'd3, 3'd0, 0, 0, 1, 0);
    check("R9 shift add flags", flags_next, 4'b1000);
    run("R9 shift neg", 16'hFFFF, 2'd3, 16'h0, 2'd0, 2'd0, 3'd0, 0, 0, 1, 0);
    check("R9 shift neg z", z_out, 16'h7FFF);
  endtask

  task automatic t_hold;
    run("R10 load", 16'h8000, 2'd3, 16'h0, 2'd0, 2'd0, 3'd7, 0, 0, 0, 1);
    run("R10 no load a", 16'h0000, 2'd3, 16'h0, 2'd0, 2'd0, 3'd7, 0, 0, 0, 0);
    run("R10 no load b", 16'hFFFF, 2'd1, 16'h0, 2'd1, 2'd3, 3'd0, 0, 0, 0, 0);
    run("R10 final", 16'h0001, 2'd3, 16'h0, 2'd0, 2'd3, 3'd0, 0, 0, 0, 0);
    check("R10 held value", flags_q, 4'b0100);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sources();
    t_ops();
    t_flags();
    t_carry();
    t_byte();
    t_shift();
    t_hold();
    @(negedge clk);
    check("R10 end flags", flags_q, exp_q);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule